// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block turns a virtual page number and a byte offset into a physical address. The translation table is a hash table with chained collision lists. The page number is hashed to pick a bucket. The bucket memory holds one head pointer per bucket. The walker then follows the linked nodes in a node memory, one node per clock. It compares each node's stored page number with the requested one. A match returns the node's frame number joined to the request offset. Reaching the end of the chain reports a miss.

Both memories are synchronous RAMs that sit outside the block. Each returns data on the clock after its read enable. The table is loaded before any lookup, and the block only reads it. A walk that visits a set maximum number of nodes without finding a match or a chain end stops with an error. This guards against corrupted or circular chains. Every response carries the number of nodes visited.

Control is one state machine with four states:
- `ST_IDLE`: ready for a request.
- `ST_HEAD`: the bucket head pointer is arriving.
- `ST_NODE`: a node word is arriving.
- `ST_RESP`: the response is presented for one cycle.

The transitions are:
- ACCEPT: IDLE to HEAD.
- EMPTY: HEAD to RESP, when the bucket is empty.
- FIRST: HEAD to NODE.
- NEXT: NODE to NODE.
- FOUND, END and ABORT: NODE to RESP.
- RETURN: RESP to IDLE.

Top module: `hpt_walker`

## Requirements
- R1: After reset the block holds `rsp_valid` low and `req_ready` high, with both memory read enables low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response cycle is over. A `req_valid` raised while the block is busy is ignored: it produces no extra response and does not change the pending one.
- R3: In the accept cycle, `bkt_rd_en` is high and `bkt_rd_addr` equals the hash of `req_vpn`. The hash splits the page number into BKT_W-bit slices from the least significant bit, zero-pads the top slice and XORs all the slices together.
- R4: A head pointer of all ones marks an empty bucket. The result is a miss with `rsp_visits` equal to 0.
- R5: A node word is laid out as {page[VPN_W], frame[PFN_W], next[PTR_W]}, with the next pointer in the low bits. Nodes are read in chain order, starting with the head pointer and then each node's next pointer. The walker issues one node read per cycle.
- R6: On a match, `rsp_hit` is 1, `rsp_paddr` is {frame, offset}, and `rsp_visits` is the 1-based position of the matching node.
- R7: A non-matching node whose next pointer is all ones ends the walk as a miss, with `rsp_hit` and `rsp_err` at 0, `rsp_paddr` at 0 and `rsp_visits` equal to the chain length.
- R8: When MAX_WALK nodes have been visited with no match and the last next pointer is not all ones, the walk ends with `rsp_err` at 1, `rsp_hit` at 0 and `rsp_visits` equal to MAX_WALK.
- R9: `rsp_valid` is a single-cycle pulse in the cycle that comes visits+2 clock edges after the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Byte offset within the page |
| req_ready | output | 1 | Block idle, request can be taken |
| bkt_rd_en | output | 1 | Bucket memory read enable |
| bkt_rd_addr | output | BKT_W | Bucket index |
| bkt_rd_data | input | PTR_W | Head pointer, one cycle after enable |
| node_rd_en | output | 1 | Node memory read enable |
| node_rd_addr | output | PTR_W | Node index |
| node_rd_data | input | VPN_W+PFN_W+PTR_W | Node word, one cycle after enable |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_err | output | 1 | Walk aborted at MAX_WALK |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on hit, else 0 |
| rsp_visits | output | $clog2(MAX_WALK+1) | Nodes visited |

## Verification
The assertions assume the following about the block's inputs:
- Both memories answer exactly one cycle after their read enable.
- Every head or next pointer that is not null names a node that has been loaded.
- Reset is held low for at least one clock.

The bench models both memories with a fixed one-cycle read. It loads only chains whose pointers stay inside the populated node range, and it keeps one deliberately self-referencing node to exercise the abort path. Spurious requests are driven only while the walker is busy, to check that they are ignored.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_NODE,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  key,
    output logic [OUT_W-1:0] idx
);
    localparam int NSLICE = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W  = NSLICE * OUT_W;

    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] acc [NSLICE+1];

    assign padded = PAD_W'(key);
    assign acc[0] = '0;

    // fold every slice into the running XOR
    for (genvar g = 0; g < NSLICE; g++) begin : g_fold
        assign acc[g+1] = acc[g] ^ padded[g*OUT_W +: OUT_W];
    end

    assign idx = acc[NSLICE];
endmodule

// File: rtl/hpt_node_eval.sv
module hpt_node_eval #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 17,
    parameter int PTR_W = 5
) (
    input  logic [VPN_W+PFN_W+PTR_W-1:0] word,
    input  logic [VPN_W-1:0]             want,
    output logic                         match,
    output logic                         is_last,
    output logic [PFN_W-1:0]             pfn,
    output logic [PTR_W-1:0]             next
);
    localparam int NODE_W = VPN_W + PFN_W + PTR_W;

    logic [VPN_W-1:0] stored_vpn;

    assign stored_vpn = word[NODE_W-1 -: VPN_W];
    assign pfn        = word[PTR_W +: PFN_W];
    assign next       = word[PTR_W-1:0];
    assign match      = (stored_vpn == want);
    assign is_last    = &next;
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int OFF_W    = 12,
    parameter int PFN_W    = 17,
    parameter int BKT_W    = 4,
    parameter int PTR_W    = 5,
    parameter int MAX_WALK = 8,
    localparam int NODE_W  = VPN_W + PFN_W + PTR_W,
    localparam int PA_W    = PFN_W + OFF_W,
    localparam int CNT_W   = $clog2(MAX_WALK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    output logic              req_ready,
    output logic              bkt_rd_en,
    output logic [BKT_W-1:0]  bkt_rd_addr,
    input  logic [PTR_W-1:0]  bkt_rd_data,
    output logic              node_rd_en,
    output logic [PTR_W-1:0]  node_rd_addr,
    input  logic [NODE_W-1:0] node_rd_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [CNT_W-1:0]  rsp_visits
);
    localparam logic [CNT_W-1:0] WALK_LIMIT = CNT_W'(MAX_WALK);

    walk_state_t      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic [PFN_W-1:0] pfn_q, pfn_d;
    logic [CNT_W-1:0] visits_q, visits_d, visits_inc;
    logic             hit_q, hit_d, err_q, err_d;
    logic             take_req, head_null, chase_go;

    logic [BKT_W-1:0] hash_idx;
    logic             nd_match, nd_last;
    logic [PFN_W-1:0] nd_pfn;
    logic [PTR_W-1:0] nd_next;

    hpt_hash #(.IN_W(VPN_W), .OUT_W(BKT_W)) u_hash (
        .key (req_vpn),
        .idx (hash_idx)
    );

    hpt_node_eval #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PTR_W(PTR_W)) u_eval (
        .word    (node_rd_data),
        .want    (vpn_q),
        .match   (nd_match),
        .is_last (nd_last),
        .pfn     (nd_pfn),
        .next    (nd_next)
    );

    assign take_req   = (state_q == ST_IDLE) && req_valid;
    assign head_null  = &bkt_rd_data;
    assign visits_inc = visits_q + CNT_W'(1);

    // transition logic
    always_comb begin
        state_d  = state_q;
        visits_d = visits_q;
        hit_d    = hit_q;
        err_d    = err_q;
        pfn_d    = pfn_q;
        chase_go = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_req) begin            // ACCEPT
                    state_d  = ST_HEAD;
                    visits_d = '0;
                    hit_d    = 1'b0;
                    err_d    = 1'b0;
                    pfn_d    = '0;
                end
            end
            ST_HEAD: begin
                if (head_null) begin           // EMPTY
                    state_d = ST_RESP;
                end else begin                 // FIRST
                    state_d  = ST_NODE;
                    chase_go = 1'b1;
                end
            end
            ST_NODE: begin
                visits_d = visits_inc;
                if (nd_match) begin            // FOUND
                    state_d = ST_RESP;
                    hit_d   = 1'b1;
                    pfn_d   = nd_pfn;
                end else if (nd_last) begin    // END
                    state_d = ST_RESP;
                end else if (visits_inc == WALK_LIMIT) begin  // ABORT
                    state_d = ST_RESP;
                    err_d   = 1'b1;
                end else begin                 // NEXT
                    chase_go = 1'b1;
                end
            end
            ST_RESP: begin                     // RETURN
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            vpn_q    <= '0;
            off_q    <= '0;
            pfn_q    <= '0;
            visits_q <= '0;
            hit_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            visits_q <= visits_d;
            hit_q    <= hit_d;
            err_q    <= err_d;
            pfn_q    <= pfn_d;
            if (take_req) begin
                vpn_q <= req_vpn;
                off_q <= req_off;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        bkt_rd_en    = take_req;
        bkt_rd_addr  = hash_idx;
        node_rd_en   = chase_go;
        node_rd_addr = (state_q == ST_HEAD) ? bkt_rd_data : nd_next;
        rsp_valid    = (state_q == ST_RESP);
        rsp_hit      = hit_q;
        rsp_err      = err_q;
        rsp_visits   = visits_q;
        rsp_paddr    = hit_q ? {pfn_q, off_q} : '0;
    end

    // R2: after a request is taken the block is busy
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R2: the cycle after a response the block is idle again
    a_r2_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R9: one-cycle response pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: hit and error never together
    a_r8_hit_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_err));

    // R8: visit count never passes the walk limit
    a_r8_visit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_visits <= WALK_LIMIT));

    // R4: an empty bucket yields a plain miss
    a_r4_empty_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_visits == '0) |-> !rsp_hit && !rsp_err);

    // R5: the bucket and node memories are never read in the same cycle
    a_r5_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(bkt_rd_en && node_rd_en));

    // R7: a miss carries a zero address
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> (rsp_paddr == '0));
endmodule

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
module tb_hpt_walker;
    localparam int VPN_W    = 20;
    localparam int OFF_W    = 12;
    localparam int PFN_W    = 17;
    localparam int BKT_W    = 4;
    localparam int PTR_W    = 5;
    localparam int MAX_WALK = 8;
    localparam int NODE_W   = VPN_W + PFN_W + PTR_W;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int CNT_W    = $clog2(MAX_WALK + 1);
    localparam logic [PTR_W-1:0] NUL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic              req_ready;
    logic              bkt_rd_en;
    logic [BKT_W-1:0]  bkt_rd_addr;
    logic [PTR_W-1:0]  bkt_rd_data = '1;
    logic              node_rd_en;
    logic [PTR_W-1:0]  node_rd_addr;
    logic [NODE_W-1:0] node_rd_data = '0;
    logic              rsp_valid, rsp_hit, rsp_err;
    logic [PA_W-1:0]   rsp_paddr;
    logic [CNT_W-1:0]  rsp_visits;

    int total = 0;
    int bad   = 0;

    logic [PTR_W-1:0]  bkt_mem  [1 << BKT_W];
    logic [NODE_W-1:0] node_mem [1 << PTR_W];
    int                ref_path [MAX_WALK];

    always #5 clk = ~clk;

    hpt_walker #(
        .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
        .BKT_W(BKT_W), .PTR_W(PTR_W), .MAX_WALK(MAX_WALK)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
        .req_ready(req_ready),
        .bkt_rd_en(bkt_rd_en), .bkt_rd_addr(bkt_rd_addr), .bkt_rd_data(bkt_rd_data),
        .node_rd_en(node_rd_en), .node_rd_addr(node_rd_addr), .node_rd_data(node_rd_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_paddr(rsp_paddr), .rsp_visits(rsp_visits)
    );

    // memory models: one-cycle synchronous read
    always @(posedge clk) begin
        if (bkt_rd_en)  bkt_rd_data  <= bkt_mem[bkt_rd_addr];
        if (node_rd_en) node_rd_data <= node_mem[node_rd_addr];
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [BKT_W-1:0] ref_hash(input logic [VPN_W-1:0] v);
        logic [BKT_W-1:0] h = '0;
        for (int i = 0; i < VPN_W; i++) h[i % BKT_W] = h[i % BKT_W] ^ v[i];
        return h;
    endfunction

    function automatic logic [VPN_W-1:0] mkvpn(input int b, input int k);
        return VPN_W'(b | (k << 4) | (k << 8));
    endfunction

    function automatic logic [PFN_W-1:0] mkpfn(input int b, input int k);
        return PFN_W'(b * 4099 + k * 257 + 3);
    endfunction

    task automatic ref_walk(input logic [VPN_W-1:0] v, output logic hit, output logic err,
                            output logic [PFN_W-1:0] pfn, output int n);
        logic [PTR_W-1:0]  ptr;
        logic [NODE_W-1:0] w;
        hit = 0; err = 0; pfn = '0; n = 0;
        ptr = bkt_mem[ref_hash(v)];
        while (ptr != NUL) begin
            ref_path[n] = int'(ptr);
            n++;
            w = node_mem[ptr];
            if (w[NODE_W-1 -: VPN_W] == v) begin
                hit = 1; pfn = w[PTR_W +: PFN_W];
                break;
            end
            if (w[PTR_W-1:0] == NUL) break;
            if (n == MAX_WALK) begin
                err = 1;
                break;
            end
            ptr = w[PTR_W-1:0];
        end
    endtask

    task automatic chain(input int b, input int first, input int len);
        bkt_mem[b] = PTR_W'(first);
        for (int k = 1; k <= len; k++)
            node_mem[first + k - 1] = {mkvpn(b, k), mkpfn(b, k),
                                       (k == len) ? NUL : PTR_W'(first + k)};
    endtask

    // one lookup, compared against the model on every clock
    task automatic run(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off);
        logic hit, err;
        logic [PFN_W-1:0] pfn;
        int n;
        ref_walk(v, hit, err, pfn, n);
        @(negedge clk);
        chk("R2 ready when idle", req_ready, 1);
        chk("R9 no response while idle", rsp_valid, 0);
        req_valid = 1; req_vpn = v; req_off = off;
        #1;
        chk("R3 bucket read enable", bkt_rd_en, 1);
        chk("R3 bucket index", bkt_rd_addr, ref_hash(v));
        @(negedge clk);
        req_vpn = ~v;              // spurious request while busy (R2)
        for (int m = 1; m <= n + 2; m++) begin
            if (m > 1) @(negedge clk);
            if (m == 2) req_valid = 0;
            chk("R9 response timing", rsp_valid, (m == n + 2));
            if (m < n + 2) chk("R2 busy", req_ready, 0);
            if (m <= n) begin
                chk("R5 node read enable", node_rd_en, 1);
                chk("R5 node read order", node_rd_addr, ref_path[m-1]);
            end
            if (m == n + 2) begin
                chk(err ? "R8 error flag" : "R6 R7 error flag", rsp_err, err);
                chk(hit ? "R6 hit flag" : "R7 hit flag", rsp_hit, hit);
                chk(hit ? "R6 paddr" : "R7 paddr", rsp_paddr, hit ? {pfn, off} : '0);
                chk(n == 0 ? "R4 visits" : "R6 R7 R8 visits", rsp_visits, n);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << BKT_W); i++) bkt_mem[i] = NUL;
        for (int i = 0; i < (1 << PTR_W); i++) node_mem[i] = '0;
        chain(1, 0, 1);
        chain(2, 1, 3);
        chain(3, 4, 8);
        chain(4, 12, 10);
        bkt_mem[5] = 5'd22;
        node_mem[22] = {mkvpn(5, 1), mkpfn(5, 1), 5'd22};   // self loop

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 no bucket read", bkt_rd_en, 0);
        chk("R1 no node read", node_rd_en, 0);
        chk("R1 no response", rsp_valid, 0);

        run(mkvpn(0, 1), 12'h123);    // R4 empty bucket
        run(mkvpn(6, 3), 12'hFFF);    // R4 another empty bucket
        run(mkvpn(1, 1), 12'h001);    // R6 single node hit
        run(mkvpn(1, 2), 12'h0AA);    // R7 single node miss
        run(mkvpn(2, 2), 12'h555);    // R6 middle of chain
        run(mkvpn(2, 3), 12'hABC);    // R6 last of chain
        run(mkvpn(2, 7), 12'h777);    // R7 miss after three
        run(mkvpn(3, 8), 12'h808);    // R6 hit at limit
        run(mkvpn(3, 9), 12'h909);    // R7 miss at limit length
        run(mkvpn(4, 8), 12'h408);    // R6 hit at limit in long chain
        run(mkvpn(4, 9), 12'h409);    // R8 abort
        run(mkvpn(5, 1), 12'h501);    // R6 hit on looping node
        run(mkvpn(5, 2), 12'h502);    // R8 abort on loop
        run(20'hABCDE, 12'h3C3);      // arbitrary page number
        run(mkvpn(2, 1), 12'h000);    // R6 head of chain

        @(negedge clk);
        chk("R9 quiet after last", rsp_valid, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule